// File: doc/BRIEF.md
# Ready-Line Handshake Master Controller

This block is the master side of a two-wire readiness handshake that frames traffic on a byte-serial link. It drives an active-low master-ready line (`mrdyN`) and watches an active-low slave-ready line (`srdyN`). Either side can open a transaction window. The local user opens one by raising `txReq` with a byte count. The remote side opens one by pulling its ready line low. Bytes may move only while both lines are low. The `xferEn` output tells the serial engine when to move them.

The serial engine reports each byte with `txDone` (one byte sent) or `rxDone` (one byte received). A frame parser gives the expected receive length on `rxLen` with a `rxLenValid` strobe. The controller closes the window by raising `mrdyN` once both directions have their expected byte counts. It then waits for the remote side to release its line before it returns to idle. A programmable limit bounds every wait on the remote line. When that limit expires, the controller raises `tmoErr` and goes back to idle.

The slave-ready input passes through a synchronizer before any logic uses it.

Top module: `rdy_hs_master`

## Requirements
- R1: After reset, `mrdyN` is 1, `xferEn` is 0 and `tmoErr` is 0.
- R2: In idle, with the synchronized slave line high, `txReq` = 1 on a rising edge makes `mrdyN` go low after that edge. This is a locally started window, and it transmits `txLen` bytes.
- R3: In idle, a low level on `srdyN` that reaches the two-stage synchronizer opens a remotely started window. `mrdyN` falls after the third rising edge following the fall of `srdyN`, and that window transmits 0 bytes. When `txReq` and the `srdyN` fall arrive in the same cycle, the window counts as locally started, because the synchronized line is still high.
- R4: `xferEn` is 1 only while `mrdyN` is 0, the synchronized slave line is low, and at least one byte counter is still short of its target.
- R5: The window closes once the number of `txDone` pulses counted in the window has reached the transmit target, and the receive side is also satisfied. A strobe that is driven in the cycle before a rising edge counts at that edge. `mrdyN` rises after the second rising edge following the last strobe needed.
- R6: The receive side is satisfied when a length has arrived through `rxLenValid` and the `rxDone` count has reached it. In a locally started window only, the receive side is also satisfied while no length has arrived and no byte has been received. A locally started window with a zero transmit count therefore closes with no bytes moved.
- R7: After `mrdyN` rises, it stays high and `txReq` is ignored until the synchronized slave line has gone high. Only then does the controller return to idle.
- R8: If the slave line fails to fall within `tmoLimit`+1 cycles of waiting, `mrdyN` returns high and `tmoErr` pulses for exactly one cycle. The same applies when the slave line fails to rise after the window has closed.
- R9: `txDone` and `rxDone` pulses that arrive outside an open, active window do not count toward any byte target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| txReq | input | 1 | Request to open a window and send a frame |
| txLen | input | CNT_W | Bytes to send, taken when the window opens |
| tmoLimit | input | TMO_W | Wait limit on the slave line, in cycles minus one |
| srdyN | input | 1 | Slave-ready, active low, asynchronous |
| mrdyN | output | 1 | Master-ready, active low |
| xferEn | output | 1 | Byte movement permitted |
| txDone | input | 1 | One byte has been sent |
| rxDone | input | 1 | One byte has been received |
| rxLenValid | input | 1 | `rxLen` carries the expected receive byte count |
| rxLen | input | CNT_W | Expected receive byte count |
| tmoErr | output | 1 | One-cycle pulse when a wait on the slave line expires |

## Verification
The bench runs every combination of transmit count 0 to 3 and receive count 0 to 3 under three ways of opening a window: a local request, a remote pull-down, and both in the same cycle. The remote side answers after 0 to 2 cycles of delay. The opening mode separates the locally started receive rule from the remote one. The zero counts show whether the controller closes at once or waits for a length. The unequal counts show whether the close waits for the slower direction. Separate runs cover a remote side that never answers, and byte strobes injected while the controller waits for the slave.

// File: rtl/rhm_pkg.sv
package rhm_pkg;

  typedef enum logic [1:0] {
    HS_IDLE,
    HS_WAIT_RDY,
    HS_ACTIVE,
    HS_WAIT_REL
  } hsState_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic clrCnt;     // open a window: clear counters, latch targets
    logic takeTx;     // window carries a local frame
    logic slaveInit;  // remote side opened the window
    logic countEn;    // byte strobes are counted
  } hsStrobe_t;

endpackage

// File: rtl/rhm_dp.sv
module rhm_dp
  import rhm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             srdyN,
  input  hsStrobe_t        strb,
  input  logic [CNT_W-1:0] txLen,
  input  logic             txDone,
  input  logic             rxDone,
  input  logic             rxLenValid,
  input  logic [CNT_W-1:0] rxLen,
  output logic             srdyLow,
  output logic             txSat,
  output logic             rxSat
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_W-1:0] txCnt, rxCnt, txTarget, rxTarget;
  logic rxKnown, slaveFlag;

  // slave line synchronizer, resets to "not ready"
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], srdyN};
  end
  assign srdyLow = ~syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txCnt     <= '0;
      rxCnt     <= '0;
      txTarget  <= '0;
      rxTarget  <= '0;
      rxKnown   <= 1'b0;
      slaveFlag <= 1'b0;
    end else if (strb.clrCnt) begin
      txCnt     <= '0;
      rxCnt     <= '0;
      txTarget  <= strb.takeTx ? txLen : '0;
      rxTarget  <= '0;
      rxKnown   <= 1'b0;
      slaveFlag <= strb.slaveInit;
    end else if (strb.countEn) begin
      if (txDone) txCnt <= txCnt + 1'b1;
      if (rxDone) rxCnt <= rxCnt + 1'b1;
      if (rxLenValid) begin
        rxKnown  <= 1'b1;
        rxTarget <= rxLen;
      end
    end
  end

  assign txSat = (txCnt >= txTarget);
  assign rxSat = rxKnown ? (rxCnt >= rxTarget) : (!slaveFlag && rxCnt == '0);

endmodule

// File: rtl/rhm_ctrl.sv
module rhm_ctrl
  import rhm_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txReq,
  input  logic [TMO_W-1:0] tmoLimit,
  input  logic             srdyLow,
  input  logic             txSat,
  input  logic             rxSat,
  output hsState_e         hsState,
  output hsStrobe_t        strb,
  output logic             mrdyN,
  output logic             xferEn,
  output logic             tmoErr
);

  hsState_e stNext;
  logic [TMO_W-1:0] tmoCnt;
  logic tmoHit, errNext, allSat;

  assign tmoHit = (tmoCnt == tmoLimit);
  assign allSat = txSat && rxSat;

  always_comb begin
    stNext  = hsState;
    strb    = '0;
    errNext = 1'b0;
    case (hsState)
      HS_IDLE: begin
        if (txReq || srdyLow) begin
          strb.clrCnt    = 1'b1;
          strb.takeTx    = txReq;
          strb.slaveInit = srdyLow && !txReq;
          stNext         = srdyLow ? HS_ACTIVE : HS_WAIT_RDY;
        end
      end
      HS_WAIT_RDY: begin
        if (srdyLow) stNext = HS_ACTIVE;
        else if (tmoHit) begin
          errNext = 1'b1;
          stNext  = HS_IDLE;
        end
      end
      HS_ACTIVE: begin
        strb.countEn = 1'b1;
        if (allSat) stNext = HS_WAIT_REL;
      end
      HS_WAIT_REL: begin
        if (!srdyLow) stNext = HS_IDLE;
        else if (tmoHit) begin
          errNext = 1'b1;
          stNext  = HS_IDLE;
        end
      end
      default: stNext = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsState <= HS_IDLE;
      tmoErr  <= 1'b0;
      tmoCnt  <= '0;
    end else begin
      hsState <= stNext;
      tmoErr  <= errNext;
      if (stNext != hsState) tmoCnt <= '0;
      else if (!tmoHit)      tmoCnt <= tmoCnt + 1'b1;
    end
  end

  assign mrdyN  = !(hsState == HS_WAIT_RDY || hsState == HS_ACTIVE);
  assign xferEn = (hsState == HS_ACTIVE) && srdyLow && !allSat;

endmodule

// File: rtl/rdy_hs_master.sv
module rdy_hs_master
  import rhm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int TMO_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txReq,
  input  logic [CNT_W-1:0] txLen,
  input  logic [TMO_W-1:0] tmoLimit,
  input  logic             srdyN,
  output logic             mrdyN,
  output logic             xferEn,
  input  logic             txDone,
  input  logic             rxDone,
  input  logic             rxLenValid,
  input  logic [CNT_W-1:0] rxLen,
  output logic             tmoErr
);

  hsState_e  hsState;
  hsStrobe_t strb;
  logic srdyLow, txSat, rxSat;

  rhm_ctrl #(.TMO_W(TMO_W)) uCtrl (
    .clk(clk), .rstN(rstN), .txReq(txReq), .tmoLimit(tmoLimit),
    .srdyLow(srdyLow), .txSat(txSat), .rxSat(rxSat),
    .hsState(hsState), .strb(strb), .mrdyN(mrdyN), .xferEn(xferEn),
    .tmoErr(tmoErr)
  );

  rhm_dp #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .srdyN(srdyN), .strb(strb), .txLen(txLen),
    .txDone(txDone), .rxDone(rxDone), .rxLenValid(rxLenValid),
    .rxLen(rxLen), .srdyLow(srdyLow), .txSat(txSat), .rxSat(rxSat)
  );

endmodule

// File: rtl/rdy_hs_master_chk.sv
module rdy_hs_master_chk
  import rhm_pkg::*;
(
  input logic     clk,
  input logic     rstN,
  input logic     txReq,
  input logic     mrdyN,
  input logic     xferEn,
  input logic     tmoErr,
  input logic     srdyLow,
  input hsState_e hsState
);

  // R4
  xfer_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferEn |-> (!mrdyN && srdyLow));

  // R2
  local_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hsState == HS_IDLE && txReq && !srdyLow) |=> !mrdyN);

  // R3
  remote_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hsState == HS_IDLE && srdyLow) |=> (!mrdyN && hsState == HS_ACTIVE));

  // R7
  hold_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mrdyN) |=> mrdyN);

  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    tmoErr |=> !tmoErr);

  // R8
  err_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    tmoErr |-> (mrdyN && hsState == HS_IDLE));

endmodule

bind rdy_hs_master rdy_hs_master_chk chk (
  .clk(clk), .rstN(rstN), .txReq(txReq), .mrdyN(mrdyN), .xferEn(xferEn),
  .tmoErr(tmoErr), .srdyLow(srdyLow), .hsState(hsState)
);

// File: tb/tb_rdy_hs_master.sv
module tb_rdy_hs_master;

  localparam int CNT_W = 4;
  localparam int TMO_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txReq = 1'b0;
  logic [CNT_W-1:0] txLen = '0;
  logic [TMO_W-1:0] tmoLimit = TMO_W'(10);
  logic srdyN = 1'b1;
  logic mrdyN, xferEn, tmoErr;
  logic txDone = 1'b0;
  logic rxDone = 1'b0;
  logic rxLenValid = 1'b0;
  logic [CNT_W-1:0] rxLen = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int gateBad = 0;
  int tmoSeen = 0;

  always #4 clk = ~clk;

  rdy_hs_master #(.CNT_W(CNT_W), .TMO_W(TMO_W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rstN(rstN), .txReq(txReq), .txLen(txLen), .tmoLimit(tmoLimit),
    .srdyN(srdyN), .mrdyN(mrdyN), .xferEn(xferEn), .txDone(txDone),
    .rxDone(rxDone), .rxLenValid(rxLenValid), .rxLen(rxLen), .tmoErr(tmoErr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // advance to the next falling edge and watch the lines there
  task automatic tick();
    @(negedge clk);
    cyc++;
    if (xferEn && (mrdyN || srdyN)) gateBad++;
    if (tmoErr) tmoSeen++;
  endtask

  // mode 0: local request, 1: remote pull-down, 2: both at once
  task automatic runWindow(input int mode, input int tl, input int rl,
                           input int dly, input bit noise);
    int waitCnt, expTx, expRx, sentTx, sentRx, txLeft, rxLeft, lastIdx, lowCnt;
    bit lenSent, closed;
    gateBad = 0;
    tmoSeen = 0;
    if (mode != 1) begin
      txReq = 1'b1;
      txLen = CNT_W'(tl);
    end
    if (mode != 0) srdyN = 1'b0;
    waitCnt = 0;
    do begin
      tick();
      waitCnt++;
    end while (mrdyN && waitCnt < 20);
    if (mode == 1)
      chk(waitCnt == 3, "R3 remote open delay", waitCnt, 3);
    else
      chk(waitCnt == 1, "R2 local open delay", waitCnt, 1);
    txReq = 1'b0;
    if (srdyN) begin
      for (int i = 0; i < dly; i++) begin
        txDone = noise;
        rxDone = noise;
        tick();
      end
      txDone = 1'b0;
      rxDone = 1'b0;
      srdyN  = 1'b0;
    end
    expTx  = (mode == 1) ? 0 : tl;
    expRx  = (mode != 1 && expTx == 0) ? 0 : rl;
    txLeft = expTx;
    rxLeft = rl;
    sentTx = 0;
    sentRx = 0;
    lenSent = 1'b0;
    closed  = 1'b0;
    lastIdx = -1;
    for (int i = 0; i < 60; i++) begin
      tick();
      txDone = 1'b0;
      rxDone = 1'b0;
      rxLenValid = 1'b0;
      if (mrdyN) begin
        closed = 1'b1;
        break;
      end
      if (xferEn) begin
        if (!lenSent) begin
          rxLenValid = 1'b1;
          rxLen = CNT_W'(rl);
          lenSent = 1'b1;
          lastIdx = cyc;
        end
        if (txLeft > 0) begin
          txDone = 1'b1; txLeft--; sentTx++; lastIdx = cyc;
        end
        if (rxLeft > 0) begin
          rxDone = 1'b1; rxLeft--; sentRx++; lastIdx = cyc;
        end
      end
    end
    chk(closed, "R5 window closed", int'(closed), 1);
    chk(sentTx == expTx, "R5 tx bytes moved", sentTx, expTx);
    chk(sentRx == expRx, "R6 rx bytes moved", sentRx, expRx);
    if (lastIdx >= 0)
      chk(cyc - lastIdx == 2, "R5 close delay", cyc - lastIdx, 2);
    chk(gateBad == 0, "R4 transfer gate", gateBad, 0);
    // remote still holds its line: a new request must be ignored
    txReq = 1'b1;
    lowCnt = 0;
    for (int i = 0; i < 3; i++) begin
      tick();
      if (!mrdyN) lowCnt++;
    end
    chk(lowCnt == 0, "R7 no reopen before release", lowCnt, 0);
    txReq = 1'b0;
    srdyN = 1'b1;
    for (int i = 0; i < 4; i++) tick();
    chk(mrdyN && tmoSeen == 0, "R7 clean return to idle", tmoSeen, 0);
  endtask

  initial begin
    int lowCnt;
    repeat (3) tick();
    chk(mrdyN === 1'b1, "R1 mrdyN at reset", int'(mrdyN), 1);
    chk(xferEn === 1'b0, "R1 xferEn at reset", int'(xferEn), 0);
    chk(tmoErr === 1'b0, "R1 tmoErr at reset", int'(tmoErr), 0);
    rstN = 1'b1;
    repeat (2) tick();

    for (int m = 0; m < 3; m++)
      for (int t = 0; t < 4; t++)
        for (int r = 0; r < 4; r++)
          runWindow(m, t, r, (t + r) % 3, 1'b0);

    // R9: strobes while waiting for the slave do not count
    runWindow(0, 2, 1, 2, 1'b1);
    runWindow(0, 3, 0, 1, 1'b1);

    // R8: remote never answers
    tmoLimit = TMO_W'(4);
    tmoSeen = 0;
    txReq = 1'b1;
    txLen = CNT_W'(1);
    tick();
    txReq = 1'b0;
    lowCnt = 0;
    while (!mrdyN && lowCnt < 30) begin
      lowCnt++;
      tick();
    end
    chk(lowCnt == 5, "R8 wait length", lowCnt, 5);
    chk(tmoErr === 1'b1, "R8 error raised", int'(tmoErr), 1);
    tick();
    chk(tmoErr === 1'b0, "R8 error single pulse", int'(tmoErr), 0);
    chk(mrdyN === 1'b1 && tmoSeen == 1, "R8 back to idle", tmoSeen, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule